// File: doc/BRIEF.md
# Polyphase Filter Bank Front End

This block sits directly ahead of a streaming FFT and turns a plain sample stream into a filtered stream of the same frame length. For each position inside an FFT frame it forms a short FIR across that position in the current frame and the `TAPS-1` frames before it. Each of these branch filters has its own coefficients. The FFT therefore sees data drawn from a window `TAPS` frames long rather than one, and its channels come out with steeper edges and less leakage.

The input is one signed real sample per clock, qualified by `in_valid`, with `in_sync` marking the first sample of a frame. The output is one signed filtered sample per accepted input, delayed by two clocks. `out_sync` marks frame position 0, so the FFT can lock to it directly. The coefficients are supplied as one flat parameter vector, so changing the filter shape needs no change to the logic. The products are summed at full width, then rounded and clipped to the output width.

Top module: `pfb_frontend`

## Requirements
- R1: After reset `out_valid` and `out_sync` are low, and no output is produced for any samples accepted before the first `in_sync`.
- R2: Output for position n (0..N-1) of frame m equals the sum over t in 0..TAPS-1 of `c[t*N+n] * x[(m-t)*N+n]`, where coefficient k occupies bits `[k*CW +: CW]` of `COEF_FLAT` as a signed value and x counts accepted samples only.
- R3: The full-precision sum is rounded by adding `2^(OUT_SHIFT-1)` and then shifted right arithmetically by `OUT_SHIFT` bits.
- R4: A rounded value above `2^(OW-1)-1` is output as `2^(OW-1)-1`, and one below `-2^(OW-1)` is output as `-2^(OW-1)`.
- R5: After the first sync, the first `TAPS-1` frames produce no output. Output starts with position 0 of the `TAPS`-th frame, with `out_sync` high.
- R6: Each output appears exactly two clock cycles after the sample it belongs to is accepted, and `out_sync` is high only on position 0 outputs.
- R7: A cycle with `in_valid` low changes no state and produces no output two cycles later.
- R8: Once locked, the frame position wraps from N-1 to 0 even when no `in_sync` arrives, and output continues normally.
- R9: An `in_sync` that does not follow position N-1 restarts frame counting, so output stops until `TAPS` frames have been received since that sync.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input sample qualifier |
| in_sync | input | 1 | Marks frame position 0 on a valid sample |
| in_data | input | DW | Signed input sample |
| out_valid | output | 1 | Filtered sample present |
| out_sync | output | 1 | Filtered sample is frame position 0 |
| out_data | output | OW | Signed, rounded and saturated filtered sample |

## Verification
The outputs are compared sample by sample against a direct-form model, so a wrong internal state shows up at the ports quickly. A wrong delay-line pointer, coefficient index or frame position gives a wrong value on the next emitted sample. A wrong fill count gives early or missing output within one frame. A stalled or skipping counter makes `out_sync` slip away from position 0 on the first frame boundary after the fault. The stimulus includes an impulse, random data with gaps, patterns chosen to saturate, missing syncs and a misplaced sync. Together these exercise every branch filter and every path through the frame-counting state.

// File: rtl/pfb_pkg.sv
package pfb_pkg;

  localparam int DEF_N     = 16;
  localparam int DEF_TAPS  = 4;
  localparam int DEF_CW    = 16;
  localparam int DEF_NCOEF = DEF_N * DEF_TAPS;

  // Deterministic spread of signed coefficient values in [-16000, 16000]
  function automatic int coef_value(input int k);
    return ((k * 7919 + 1234) % 32001) - 16000;
  endfunction

  function automatic logic [DEF_NCOEF*DEF_CW-1:0] default_coefs();
    logic [DEF_NCOEF*DEF_CW-1:0] v;
    v = '0;
    for (int k = 0; k < DEF_NCOEF; k++) begin
      v[k*DEF_CW +: DEF_CW] = DEF_CW'(coef_value(k));
    end
    return v;
  endfunction

endpackage

// File: rtl/pfb_frame_ctrl.sv
module pfb_frame_ctrl #(
  parameter int N    = 16,
  parameter int TAPS = 4,
  localparam int PW  = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_sync,
  output logic [PW-1:0] pos,
  output logic          emit,
  output logic          sof
);

  localparam int FW = $clog2(TAPS + 1);
  localparam logic [FW-1:0] FULL = FW'(TAPS);
  localparam logic [PW-1:0] LAST = PW'(N - 1);

  logic          locked_q, locked_n;
  logic [PW-1:0] pos_q, pos_n;
  logic [FW-1:0] fill_q, fill_n, fill_inc;

  assign fill_inc = (fill_q == FULL) ? fill_q : fill_q + FW'(1);

  always_comb begin
    locked_n = locked_q;
    pos_n    = pos_q;
    fill_n   = fill_q;
    if (in_sync) begin
      locked_n = 1'b1;
      pos_n    = '0;
      fill_n   = (locked_q && pos_q == LAST) ? fill_inc : FW'(1);
    end else if (locked_q) begin
      pos_n = pos_q + PW'(1);
      if (pos_q == LAST) fill_n = fill_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      pos_q    <= '0;
      fill_q   <= '0;
    end else if (in_valid) begin
      locked_q <= locked_n;
      pos_q    <= pos_n;
      fill_q   <= fill_n;
    end
  end

  assign pos  = pos_n;
  assign emit = in_valid && locked_n && (fill_n == FULL);
  assign sof  = emit && (pos_n == '0);

  a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(pos_q) && $stable(fill_q) && $stable(locked_q)));

  a_r9_resync_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sync && !(locked_q && pos_q == LAST)) |=> (fill_q == FW'(1)));

  a_r5_emit_full: assert property (@(posedge clk) disable iff (!rst_n)
    emit |-> (locked_q && fill_q >= FW'(TAPS - 1)));

endmodule

// File: rtl/pfb_delay_line.sv
module pfb_delay_line #(
  parameter int DEPTH = 16,
  parameter int DW    = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);

  localparam int PW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] ptr_q, ptr_n;

  assign ptr_n = ptr_q + PW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ptr_q <= '0;
    else if (en) ptr_q <= ptr_n;
  end

  always_ff @(posedge clk) begin
    if (en) mem[ptr_q] <= din;
  end

  // Slot about to be overwritten holds the sample from DEPTH accepts ago
  assign dout = mem[ptr_q];

  a_r7_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(ptr_q));

endmodule

// File: rtl/pfb_mac.sv
module pfb_mac #(
  parameter int N     = 16,
  parameter int TAPS  = 4,
  parameter int DW    = 12,
  parameter int CW    = 16,
  parameter int OW    = 12,
  parameter int SHIFT = 13,
  parameter logic [TAPS*N*CW-1:0] COEF_FLAT = '0,
  localparam int PW   = $clog2(N)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic                     emit,
  input  logic                     sof,
  input  logic [PW-1:0]            pos,
  input  logic [TAPS-1:0][DW-1:0]  taps_in,
  output logic                     out_valid,
  output logic                     out_sync,
  output logic [OW-1:0]            out_data
);

  localparam int PRODW = DW + CW;
  localparam int ACCW  = PRODW + $clog2(TAPS);
  localparam logic signed [ACCW-1:0] HALF = ACCW'(1) << (SHIFT - 1);
  localparam logic signed [ACCW-1:0] OMAX = {{(ACCW-OW+1){1'b0}}, {(OW-1){1'b1}}};
  localparam logic signed [ACCW-1:0] OMIN = {{(ACCW-OW+1){1'b1}}, {(OW-1){1'b0}}};

  logic signed [PRODW-1:0] prod_n [TAPS];
  logic signed [PRODW-1:0] prod_q [TAPS];
  logic                    vld_a, sof_a;
  logic signed [ACCW-1:0]  acc, shifted, clipped;

  // Stage A: one product per tap, coefficient picked by tap and frame position
  always_comb begin
    for (int t = 0; t < TAPS; t++) begin
      prod_n[t] = PRODW'($signed(taps_in[t]))
                * PRODW'($signed(COEF_FLAT[(t*N + int'(pos))*CW +: CW]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_a <= 1'b0;
      sof_a <= 1'b0;
    end else begin
      vld_a <= en && emit;
      sof_a <= en && sof;
    end
  end

  always_ff @(posedge clk) begin
    if (en && emit) begin
      for (int t = 0; t < TAPS; t++) prod_q[t] <= prod_n[t];
    end
  end

  // Stage B: full-width sum, round half up, saturate
  always_comb begin
    acc = '0;
    for (int t = 0; t < TAPS; t++) acc = acc + ACCW'(prod_q[t]);
    shifted = (acc + HALF) >>> SHIFT;
    if (shifted > OMAX)      clipped = OMAX;
    else if (shifted < OMIN) clipped = OMIN;
    else                     clipped = shifted;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sync  <= 1'b0;
    end else begin
      out_valid <= vld_a;
      out_sync  <= sof_a;
    end
  end

  always_ff @(posedge clk) begin
    if (vld_a) out_data <= clipped[OW-1:0];
  end

  a_r6_sync_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_sync |-> out_valid);

endmodule

// File: rtl/pfb_frontend.sv
module pfb_frontend #(
  parameter int N         = pfb_pkg::DEF_N,
  parameter int TAPS      = pfb_pkg::DEF_TAPS,
  parameter int DW        = 12,
  parameter int CW        = pfb_pkg::DEF_CW,
  parameter int OW        = 12,
  parameter int OUT_SHIFT = 13,
  parameter logic [TAPS*N*CW-1:0] COEF_FLAT = pfb_pkg::default_coefs()
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_sync,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  output logic          out_sync,
  output logic [OW-1:0] out_data
);

  localparam int PW = $clog2(N);

  logic                    rst_meta, rst_sync;
  logic [PW-1:0]           pos;
  logic                    emit, sof;
  logic [TAPS-1:0][DW-1:0] tap_bus;

  // Reset asserts at once, releases on the second clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  pfb_frame_ctrl #(.N(N), .TAPS(TAPS)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync),
    .in_valid (in_valid),
    .in_sync  (in_sync),
    .pos      (pos),
    .emit     (emit),
    .sof      (sof)
  );

  assign tap_bus[0] = in_data;

  for (genvar g = 1; g < TAPS; g++) begin : g_line
    pfb_delay_line #(.DEPTH(N), .DW(DW)) u_line (
      .clk   (clk),
      .rst_n (rst_sync),
      .en    (in_valid),
      .din   (tap_bus[g-1]),
      .dout  (tap_bus[g])
    );
  end

  pfb_mac #(
    .N(N), .TAPS(TAPS), .DW(DW), .CW(CW), .OW(OW),
    .SHIFT(OUT_SHIFT), .COEF_FLAT(COEF_FLAT)
  ) u_mac (
    .clk       (clk),
    .rst_n     (rst_sync),
    .en        (in_valid),
    .emit      (emit),
    .sof       (sof),
    .pos       (pos),
    .taps_in   (tap_bus),
    .out_valid (out_valid),
    .out_sync  (out_sync),
    .out_data  (out_data)
  );

  a_r6_latency: assert property (@(posedge clk) disable iff (!rst_sync)
    out_valid |-> $past(in_valid, 2));

  a_r1_quiet_before_lock: assert property (@(posedge clk) disable iff (!rst_sync)
    (in_valid && !emit) |=> ##1 !out_valid);

endmodule

// File: tb/pfb_frontend_test.sv
module pfb_frontend_test;

  localparam int CLK_P = 10;
  localparam int N     = 16;
  localparam int TAPS  = 4;
  localparam int DW    = 12;
  localparam int OW    = 12;
  localparam int SHIFT = 13;
  localparam int OMAX  = (1 << (OW - 1)) - 1;
  localparam int OMIN  = -(1 << (OW - 1));

  logic clk, rst_n, in_valid, in_sync;
  logic [DW-1:0] in_data;
  logic out_valid, out_sync;
  logic [OW-1:0] out_data;

  pfb_frontend uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sync(in_sync),
    .in_data(in_data), .out_valid(out_valid), .out_sync(out_sync), .out_data(out_data)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  int n_checks = 0, n_fail = 0, cyc = 0, out_cnt = 0;
  int sat_hi = 0, sat_lo = 0;
  string cur_req = "R2";

  int    hist[$];
  int    exp_d[$], exp_s[$], exp_due[$];
  string exp_r[$];
  bit    m_locked = 0;
  int    m_pos = 0, m_fill = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int coef(input int k);
    return pfb_pkg::coef_value(k);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv, input string what);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Direct-form reference, built from the requirements
  function automatic void model_step(input bit s, input int d);
    int j; longint acc, r;
    hist.push_back(d);
    if (s) begin
      m_fill   = (m_locked && m_pos == N-1) ? ((m_fill < TAPS) ? m_fill + 1 : TAPS) : 1;
      m_pos    = 0;
      m_locked = 1;
    end else if (m_locked) begin
      if (m_pos == N-1) m_fill = (m_fill < TAPS) ? m_fill + 1 : TAPS;
      m_pos = (m_pos + 1) % N;
    end
    if (m_locked && m_fill == TAPS) begin
      j = hist.size() - 1;
      acc = 0;
      for (int t = 0; t < TAPS; t++)
        acc += longint'(coef(t*N + m_pos)) * longint'(hist[j - t*N]);
      r = (acc + (64'sd1 <<< (SHIFT-1))) >>> SHIFT;
      if (r > OMAX) r = OMAX;
      if (r < OMIN) r = OMIN;
      exp_d.push_back(int'(r));
      exp_s.push_back(m_pos == 0);
      exp_due.push_back(cyc + 2);
      exp_r.push_back(cur_req);
    end
  endfunction

  task automatic send(input bit v, input bit s, input int d);
    @(negedge clk);
    in_valid = v;
    in_sync  = v & s;
    in_data  = DW'(d);
    if (v) model_step(s, d);
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) send(0, 0, 0);
  endtask

  function automatic int rnd_sample();
    return int'($urandom_range(0, 4095)) - 2048;
  endfunction

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      int got;
      got = int'($signed(out_data));
      out_cnt++;
      if (got == OMAX) sat_hi++;
      if (got == OMIN) sat_lo++;
      if (exp_d.size() == 0) begin
        check(0, cur_req, got, 0, "unexpected output");
      end else begin
        int ed, es, edue; string er;
        ed = exp_d.pop_front(); es = exp_s.pop_front();
        edue = exp_due.pop_front(); er = exp_r.pop_front();
        check(got == ed, er, got, ed, "data");
        check(int'(out_sync) == es, er, int'(out_sync), es, "sync");
        check(cyc == edue, "R6", cyc, edue, "latency cycle");
      end
    end
  end

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int base;
    rst_n = 0; in_valid = 0; in_sync = 0; in_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1: reset state and no output before the first sync
    cur_req = "R1";
    check(out_valid == 0, "R1", int'(out_valid), 0, "out_valid after reset");
    check(out_sync == 0, "R1", int'(out_sync), 0, "out_sync after reset");
    for (int i = 0; i < 20; i++) send(1, 0, rnd_sample());
    idle(4);
    check(out_cnt == 0, "R1", out_cnt, 0, "outputs before sync");

    // R5: fill period, then impulse response (R2)
    cur_req = "R5";
    for (int f = 0; f < TAPS-1; f++)
      for (int n = 0; n < N; n++) send(1, n == 0, (f == 1 && n == 3) ? 1000 : 0);
    idle(4);
    check(out_cnt == 0, "R5", out_cnt, 0, "outputs during fill");
    cur_req = "R2";
    for (int f = 0; f < TAPS+1; f++)
      for (int n = 0; n < N; n++) send(1, n == 0, 0);
    check(out_cnt > 0, "R5", out_cnt, 1, "output after fill");

    // R3/R7: random data with random stall cycles
    cur_req = "R7";
    for (int f = 0; f < 6; f++)
      for (int n = 0; n < N; n++) begin
        if ($urandom_range(0, 2) == 0) idle(int'($urandom_range(1, 3)));
        send(1, n == 0, rnd_sample());
      end
    cur_req = "R3";
    for (int f = 0; f < 4; f++)
      for (int n = 0; n < N; n++) send(1, n == 0, rnd_sample());

    // R4: sign patterns matched to the coefficients drive both rails
    cur_req = "R4";
    for (int pol = 0; pol < 2; pol++)
      for (int f = 0; f < TAPS; f++)
        for (int n = 0; n < N; n++) begin
          bit pos_c;
          pos_c = coef((TAPS-1-f)*N + n) >= 0;
          send(1, n == 0, ((pos_c ^ pol[0]) != 0) ? 2047 : -2048);
        end
    idle(4);
    check(sat_hi > 0, "R4", sat_hi, 1, "high saturation seen");
    check(sat_lo > 0, "R4", sat_lo, 1, "low saturation seen");

    // R8: syncs omitted, position keeps wrapping
    cur_req = "R8";
    for (int f = 0; f < 4; f++)
      for (int n = 0; n < N; n++) send(1, 0, rnd_sample());

    // R9: misplaced sync restarts the fill
    cur_req = "R9";
    for (int n = 0; n < 5; n++) send(1, 0, rnd_sample());
    idle(3);
    base = out_cnt;
    for (int f = 0; f < TAPS-1; f++)
      for (int n = 0; n < N; n++) send(1, n == 0, rnd_sample());
    idle(4);
    check(out_cnt == base, "R9", out_cnt - base, 0, "outputs after misplaced sync");
    for (int f = 0; f < 2; f++)
      for (int n = 0; n < N; n++) send(1, n == 0, rnd_sample());

    idle(6);
    check(exp_d.size() == 0, "R6", exp_d.size(), 0, "expected items left");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule